// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block does signed saturating arithmetic on packed data. It takes two 32-bit operands and an instruction word. A 3-bit operation code in the instruction word decides how the operands are split into lanes. The operands can be treated as two signed 16-bit halves or as four signed bytes. Each lane is added or subtracted on its own. When a lane result does not fit, it is clamped to the most positive or most negative value of that lane, so it never wraps.

Two exchange modes pair each half of the first operand with the opposite half of the second operand. These modes add in one half and subtract in the other. The unit also decodes the three 4-bit register index fields of the instruction word, so a surrounding execute stage can take them without decoding the word again.

A per-lane saturation vector shows which lanes were clamped. The two unused operation codes raise an illegal flag and produce a zero result. All outputs pass through an optional register stage. The register stage is present by default and is cleared by reset.

Top module: `psat_alu`

## Requirements
- R1: The destination index output equals instruction bits 15:12, the first-source index equals bits 19:16, the second-source index equals bits 3:0, and the operation code is read from bits 7:5.
- R2: Operation code 0 adds the operands as two signed halves. Code 3 subtracts them as two signed halves, first minus second. The low-half result goes to result bits 15:0 and the high-half result to bits 31:16.
- R3: Operation code 1 gives low = first[15:0] − second[31:16] and high = first[31:16] + second[15:0].
- R4: Operation code 2 gives low = first[15:0] + second[31:16] and high = first[31:16] − second[15:0].
- R5: Operation code 4 adds the operands as four independent signed bytes. Code 7 subtracts them as four independent signed bytes. Byte k sits in bits 8k+7:8k, and no carry or borrow passes between bytes.
- R6: A 16-bit lane result above 32767 becomes 0x7FFF. A 16-bit lane result below −32768 becomes 0x8000.
- R7: An 8-bit lane result above 127 becomes 0x7F. An 8-bit lane result below −128 becomes 0x80.
- R8: The saturation output bit for a lane is 1 exactly when that lane was clamped. In halfword modes, bit 0 is the low half, bit 1 is the high half, and bits 3:2 are 0. In byte modes, bit k is byte k.
- R9: For operation codes 5 and 6 the illegal output is 1, and the result and saturation outputs are 0. For every other code the illegal output is 0.
- R10: With the output register present (the default), every output reflects the inputs one clock edge later. While reset is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| instr_i | input | 32 | Instruction word carrying the operation code and index fields |
| op_a_i | input | 32 | First operand (minuend in subtraction) |
| op_b_i | input | 32 | Second operand |
| rd_idx_o | output | 4 | Destination register index |
| rn_idx_o | output | 4 | First-source register index |
| rm_idx_o | output | 4 | Second-source register index |
| result_o | output | 32 | Packed lane results |
| sat_o | output | 4 | Per-lane saturation indicators |
| illegal_o | output | 1 | Unsupported operation code |

## Verification
The hardest case to reach is the exchange modes with one half clamping while the other does not. A wrong half pairing only shows up when the crossed-over operand causes the overflow, and with random operands this is rare. The vector table therefore sets up operands where exchanging the halves decides whether a lane clamps at all. A second group of vectors sits one step past each limit (the most negative value minus one, the most positive value plus one). A byte-mode vector whose bytes would carry into each other if lanes leaked shows any cross-lane carry. A seeded pseudo-random sweep, checked against an integer model in the bench, then covers the remaining space.

// File: rtl/psat_pkg.sv
package psat_pkg;

  typedef enum logic [2:0] {
    OP_ADD16 = 3'd0,
    OP_XADD  = 3'd1,
    OP_XSUB  = 3'd2,
    OP_SUB16 = 3'd3,
    OP_ADD8  = 3'd4,
    OP_RSV5  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_SUB8  = 3'd7
  } psat_op_e;

  typedef struct packed {
    logic byte_mode;
    logic illegal;
    logic swap;
    logic lo_sub;
    logic hi_sub;
  } psat_ctrl_t;

  function automatic psat_ctrl_t decode_op(input logic [2:0] op);
    psat_ctrl_t c;
    c = '0;
    case (psat_op_e'(op))
      OP_ADD16: ;
      OP_XADD:  begin c.swap = 1'b1; c.lo_sub = 1'b1; end
      OP_XSUB:  begin c.swap = 1'b1; c.hi_sub = 1'b1; end
      OP_SUB16: begin c.lo_sub = 1'b1; c.hi_sub = 1'b1; end
      OP_ADD8:  c.byte_mode = 1'b1;
      OP_SUB8:  begin c.byte_mode = 1'b1; c.lo_sub = 1'b1; c.hi_sub = 1'b1; end
      default:  c.illegal = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/psat_decode.sv
module psat_decode #(
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4,
  parameter int OP_W    = 3,
  parameter int RD_LSB  = 12,
  parameter int RN_LSB  = 16,
  parameter int RM_LSB  = 0,
  parameter int OP_LSB  = 5
) (
  input  logic [INSTR_W-1:0]      instr_i,
  output logic [IDX_W-1:0]        rd_idx_o,
  output logic [IDX_W-1:0]        rn_idx_o,
  output logic [IDX_W-1:0]        rm_idx_o,
  output psat_pkg::psat_ctrl_t    ctrl_o
);
  logic [OP_W-1:0] op_code;
  logic            unused_bits;

  assign rd_idx_o = instr_i[RD_LSB +: IDX_W];
  assign rn_idx_o = instr_i[RN_LSB +: IDX_W];
  assign rm_idx_o = instr_i[RM_LSB +: IDX_W];
  assign op_code  = instr_i[OP_LSB +: OP_W];
  assign ctrl_o   = psat_pkg::decode_op(op_code);
  assign unused_bits = ^instr_i;
endmodule

// File: rtl/psat_lane.sv
module psat_lane #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              sub_i,
  output logic [LANE_W-1:0] y_o,
  output logic              sat_o
);
  localparam int MSB = LANE_W - 1;

  function automatic logic [LANE_W:0] clamp_op(input logic [LANE_W-1:0] a,
                                               input logic [LANE_W-1:0] b,
                                               input logic sub);
    logic [LANE_W-1:0] raw;
    logic [LANE_W-1:0] lim;
    logic              ovf;
    raw = sub ? (a - b) : (a + b);
    if (sub) ovf = (a[MSB] != b[MSB]) && (raw[MSB] != a[MSB]);
    else     ovf = (a[MSB] == b[MSB]) && (raw[MSB] != a[MSB]);
    lim = a[MSB] ? {1'b1, {MSB{1'b0}}} : {1'b0, {MSB{1'b1}}};
    return {ovf, (ovf ? lim : raw)};
  endfunction

  logic [LANE_W:0] packed_out;
  assign packed_out = clamp_op(a_i, b_i, sub_i);
  assign y_o   = packed_out[LANE_W-1:0];
  assign sat_o = packed_out[LANE_W];
endmodule

// File: rtl/psat_outreg.sv
module psat_outreg #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_pass
      logic unused_ctl;
      assign unused_ctl = clk ^ rst_n;
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/psat_alu.sv
module psat_alu #(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4,
  parameter int BYTE_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [INSTR_W-1:0]      instr_i,
  input  logic [DATA_W-1:0]       op_a_i,
  input  logic [DATA_W-1:0]       op_b_i,
  output logic [IDX_W-1:0]        rd_idx_o,
  output logic [IDX_W-1:0]        rn_idx_o,
  output logic [IDX_W-1:0]        rm_idx_o,
  output logic [DATA_W-1:0]       result_o,
  output logic [DATA_W/BYTE_W-1:0] sat_o,
  output logic                    illegal_o
);
  localparam int N_HALF  = 2;
  localparam int HALF_W  = DATA_W / N_HALF;
  localparam int N_BYTES = DATA_W / BYTE_W;
  localparam int PACK_W  = 3 * IDX_W + 1 + N_BYTES + DATA_W;

  psat_pkg::psat_ctrl_t ctrl;
  logic [IDX_W-1:0]     rd_idx, rn_idx, rm_idx;

  psat_decode #(.INSTR_W(INSTR_W), .IDX_W(IDX_W)) u_dec (
    .instr_i  (instr_i),
    .rd_idx_o (rd_idx),
    .rn_idx_o (rn_idx),
    .rm_idx_o (rm_idx),
    .ctrl_o   (ctrl)
  );

  logic [DATA_W-1:0]  half_bus;
  logic [N_HALF-1:0]  half_sat;
  logic [DATA_W-1:0]  byte_bus;
  logic [N_BYTES-1:0] byte_sat;

  genvar h;
  generate
    for (h = 0; h < N_HALF; h++) begin : g_half
      logic [HALF_W-1:0] b_sel;
      assign b_sel = ctrl.swap ? op_b_i[(N_HALF-1-h)*HALF_W +: HALF_W]
                               : op_b_i[h*HALF_W +: HALF_W];
      psat_lane #(.LANE_W(HALF_W)) u_lane (
        .a_i   (op_a_i[h*HALF_W +: HALF_W]),
        .b_i   (b_sel),
        .sub_i ((h == 0) ? ctrl.lo_sub : ctrl.hi_sub),
        .y_o   (half_bus[h*HALF_W +: HALF_W]),
        .sat_o (half_sat[h])
      );
    end
  endgenerate

  genvar k;
  generate
    for (k = 0; k < N_BYTES; k++) begin : g_byte
      psat_lane #(.LANE_W(BYTE_W)) u_lane (
        .a_i   (op_a_i[k*BYTE_W +: BYTE_W]),
        .b_i   (op_b_i[k*BYTE_W +: BYTE_W]),
        .sub_i (ctrl.lo_sub),
        .y_o   (byte_bus[k*BYTE_W +: BYTE_W]),
        .sat_o (byte_sat[k])
      );
    end
  endgenerate

  // Named internal events, observed by the bound checker
  logic [DATA_W-1:0]  nxt_result;
  logic [N_BYTES-1:0] nxt_sat;
  logic               nxt_illegal;
  logic               nxt_byte_mode;

  assign nxt_illegal   = ctrl.illegal;
  assign nxt_byte_mode = ctrl.byte_mode;

  always_comb begin
    if (ctrl.illegal) begin
      nxt_result = '0;
      nxt_sat    = '0;
    end else if (ctrl.byte_mode) begin
      nxt_result = byte_bus;
      nxt_sat    = byte_sat;
    end else begin
      nxt_result = half_bus;
      nxt_sat    = {{(N_BYTES-N_HALF){1'b0}}, half_sat};
    end
  end

  logic [PACK_W-1:0] pack_d, pack_q;
  assign pack_d = {rd_idx, rn_idx, rm_idx, nxt_illegal, nxt_sat, nxt_result};

  psat_outreg #(.W(PACK_W), .REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pack_d),
    .q_o   (pack_q)
  );

  assign {rd_idx_o, rn_idx_o, rm_idx_o, illegal_o, sat_o, result_o} = pack_q;
endmodule

// File: rtl/psat_alu_chk.sv
module psat_alu_chk #(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [DATA_W-1:0]        nxt_result,
  input logic [DATA_W/BYTE_W-1:0] nxt_sat,
  input logic                     nxt_illegal,
  input logic                     nxt_byte_mode,
  input logic [DATA_W-1:0]        result_o,
  input logic [DATA_W/BYTE_W-1:0] sat_o,
  input logic                     illegal_o
);
  localparam int N_BYTES = DATA_W / BYTE_W;
  localparam int HALF_W  = DATA_W / 2;

  logic past_valid;
  always_ff @(posedge clk) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_illegal |-> (nxt_result == '0 && nxt_sat == '0)); // R9

  AST_HALF_SAT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !nxt_byte_mode |-> (nxt_sat[N_BYTES-1:2] == '0)); // R8

  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_hchk
      AST_HALF_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!nxt_byte_mode && nxt_sat[h]) |->
          (nxt_result[h*HALF_W +: HALF_W] == {1'b0, {(HALF_W-1){1'b1}}} ||
           nxt_result[h*HALF_W +: HALF_W] == {1'b1, {(HALF_W-1){1'b0}}})); // R6
    end
  endgenerate

  genvar k;
  generate
    for (k = 0; k < N_BYTES; k++) begin : g_bchk
      AST_BYTE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_byte_mode && nxt_sat[k]) |->
          (nxt_result[k*BYTE_W +: BYTE_W] == {1'b0, {(BYTE_W-1){1'b1}}} ||
           nxt_result[k*BYTE_W +: BYTE_W] == {1'b1, {(BYTE_W-1){1'b0}}})); // R7
    end
  endgenerate

  generate
    if (REG_OUT) begin : g_lat
      AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> (result_o == $past(nxt_result) && sat_o == $past(nxt_sat)
                        && illegal_o == $past(nxt_illegal))); // R10
    end else begin : g_comb
      AST_OUT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        result_o == nxt_result && illegal_o == nxt_illegal); // R10
    end
  endgenerate
endmodule

bind psat_alu psat_alu_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .REG_OUT(REG_OUT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .nxt_result    (nxt_result),
  .nxt_sat       (nxt_sat),
  .nxt_illegal   (nxt_illegal),
  .nxt_byte_mode (nxt_byte_mode),
  .result_o      (result_o),
  .sat_o         (sat_o),
  .illegal_o     (illegal_o)
);

// File: tb/psat_alu_bench.sv
module psat_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic [3:0]  rd_idx_o, rn_idx_o, rm_idx_o;
  logic [31:0] result_o;
  logic [3:0]  sat_o;
  logic        illegal_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  psat_alu u_psat_alu (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .rd_idx_o(rd_idx_o), .rn_idx_o(rn_idx_o), .rm_idx_o(rm_idx_o),
    .result_o(result_o), .sat_o(sat_o), .illegal_o(illegal_o)
  );

  // {op, a, b, expected result, expected sat, expected illegal}
  localparam int NV = 13;
  localparam logic [103:0] VEC [NV] = '{
    {3'd0, 32'h0001_0002, 32'h0003_0004, 32'h0004_0006, 4'b0000, 1'b0},
    {3'd0, 32'h7FFF_8000, 32'h0001_FFFF, 32'h7FFF_8000, 4'b0011, 1'b0},
    {3'd3, 32'h8000_0005, 32'h0001_0007, 32'h8000_FFFE, 4'b0010, 1'b0},
    {3'd3, 32'h0000_0000, 32'h8000_0001, 32'h7FFF_FFFF, 4'b0010, 1'b0},
    {3'd1, 32'h0010_0020, 32'h0003_0005, 32'h0015_001D, 4'b0000, 1'b0},
    {3'd1, 32'h7FFF_8000, 32'h0001_0001, 32'h7FFF_8000, 4'b0011, 1'b0},
    {3'd2, 32'h0010_0020, 32'h0003_0005, 32'h000B_0023, 4'b0000, 1'b0},
    {3'd2, 32'h8000_7FFF, 32'h7FFF_0001, 32'h8000_7FFF, 4'b0011, 1'b0},
    {3'd4, 32'h7F80_0102, 32'h01FF_FF01, 32'h7F80_0003, 4'b1100, 1'b0},
    {3'd4, 32'h00FF_00FF, 32'h0001_0001, 32'h0000_0000, 4'b0000, 1'b0},
    {3'd7, 32'h8000_7F10, 32'h0100_FF20, 32'h8000_7FF0, 4'b1010, 1'b0},
    {3'd5, 32'h1234_5678, 32'h0000_0001, 32'h0000_0000, 4'b0000, 1'b1},
    {3'd6, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h0000_0000, 4'b0000, 1'b1}
  };

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0, 3'd3: return "R2 R6 R8";
      3'd1:       return "R3 R6 R8";
      3'd2:       return "R4 R6 R8";
      3'd4, 3'd7: return "R5 R7 R8";
      default:    return "R9";
    endcase
  endfunction

  function automatic logic [31:0] mk_instr(input logic [2:0] op, input logic [3:0] rd,
                                           input logic [3:0] rn, input logic [3:0] rm);
    return {12'h000, rn, rd, 4'h0, op, 1'b1, rm};
  endfunction

  // Integer model: clamp into [lo, hi], flag when clamped
  function automatic int clampi(input int v, input int lo, input int hi, output bit s);
    s = (v > hi) || (v < lo);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic [3:0] s, output logic ill);
    r = '0; s = '0; ill = 1'b0;
    if (op == 3'd5 || op == 3'd6) begin
      ill = 1'b1;
    end else if (op[2]) begin
      for (int i = 0; i < 4; i++) begin
        int x, y, z; bit f;
        x = $signed(a[i*8 +: 8]);
        y = $signed(b[i*8 +: 8]);
        z = clampi((op == 3'd7) ? x - y : x + y, -128, 127, f);
        r[i*8 +: 8] = z[7:0];
        s[i] = f;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        int x, y, z; bit f; bit sub;
        x = $signed(a[i*16 +: 16]);
        if (op == 3'd1 || op == 3'd2) y = $signed(b[(1-i)*16 +: 16]);
        else                         y = $signed(b[i*16 +: 16]);
        sub = (op == 3'd3) || (op == 3'd1 && i == 0) || (op == 3'd2 && i == 1);
        z = clampi(sub ? x - y : x + y, -32768, 32767, f);
        r[i*16 +: 16] = z[15:0];
        s[i] = f;
      end
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] er, input logic [3:0] es, input logic ei,
                     input string tag);
    logic [3:0] rd, rn, rm;
    rd = 4'(n_vec);
    rn = 4'(n_vec + 5);
    rm = 4'(n_vec + 9);
    @(negedge clk);
    instr_i = mk_instr(op, rd, rn, rm);
    op_a_i  = a;
    op_b_i  = b;
    @(posedge clk);
    #1;
    n_vec++;
    if (result_o !== er || sat_o !== es || illegal_o !== ei) begin
      n_bad++;
      $display("FAIL %s op=%0d: result %h sat %b ill %b, expected %h %b %b",
               tag, op, result_o, sat_o, illegal_o, er, es, ei);
    end
    if (rd_idx_o !== rd || rn_idx_o !== rn || rm_idx_o !== rm) begin
      n_bad++;
      $display("FAIL R1: idx %h %h %h, expected %h %h %h",
               rd_idx_o, rn_idx_o, rm_idx_o, rd, rn, rm);
    end
  endtask

  task automatic check_reset(input string tag);
    n_vec++;
    if (result_o !== '0 || sat_o !== '0 || illegal_o !== 1'b0 ||
        rd_idx_o !== '0 || rn_idx_o !== '0 || rm_idx_o !== '0) begin
      n_bad++;
      $display("FAIL %s: outputs %h %b %b %h%h%h, expected all zero",
               tag, result_o, sat_o, illegal_o, rd_idx_o, rn_idx_o, rm_idx_o);
    end
  endtask

  initial begin
    // R10: reset state with busy inputs
    instr_i = mk_instr(3'd5, 4'hF, 4'hF, 4'hF);
    op_a_i  = 32'h7FFF_7FFF;
    op_b_i  = 32'h7FFF_7FFF;
    repeat (3) @(posedge clk);
    #1;
    check_reset("R10 reset");
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [103:0] v;
      v = VEC[i];
      run(v[103:101], v[100:69], v[68:37], v[36:5], v[4:1], v[0], op_tag(v[103:101]));
    end

    // R10: one-edge latency, result changes only after the edge
    @(negedge clk);
    instr_i = mk_instr(3'd0, 4'h1, 4'h2, 4'h3);
    op_a_i  = 32'h0100_0200;
    op_b_i  = 32'h0001_0002;
    #1;
    n_vec++;
    if (result_o === 32'h0101_0202) begin
      n_bad++;
      $display("FAIL R10: result %h appeared before the edge, expected previous value", result_o);
    end
    @(posedge clk);
    #1;
    n_vec++;
    if (result_o !== 32'h0101_0202) begin
      n_bad++;
      $display("FAIL R10: result %h, expected %h", result_o, 32'h0101_0202);
    end

    // R6/R7 boundary: exactly at the limit does not clamp
    run(3'd0, 32'h7FFE_8001, 32'h0001_FFFF, 32'h7FFF_8000, 4'b0000, 1'b0, "R6 R8");
    run(3'd7, 32'h7E81_0000, 32'hFF01_0000, 32'h7F80_0000, 4'b0000, 1'b0, "R7 R8");

    // Pseudo-random sweep against the integer model
    begin
      logic [31:0] lf;
      lf = 32'hACE1_1234;
      for (int i = 0; i < 300; i++) begin
        logic [31:0] a, b, er;
        logic [3:0]  es;
        logic        ei;
        logic [2:0]  op;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        a  = lf ^ 32'h5A5A_A5A5;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        b  = {lf[15:0], lf[31:16]};
        op = 3'(i % 8);
        model(op, a, b, er, es, ei);
        run(op, a, b, er, es, ei, op_tag(op));
      end
    end

    // R10: reset in mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check_reset("R10 mid-run reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule